// File: doc/BRIEF.md
# Prescaled Real-Time Event Counter

This block is an 8-bit real-time counter for a small controller core. It counts one of two things. The first is instruction-cycle pulses from the core. The second is selected edges on an asynchronous input pin. The counter shares one prescaler with a watchdog timebase. A configuration bit decides which of the two the prescaler serves. The side that does not get the prescaler runs at 1:1. With the same 3-bit code, the counter ratio is twice the watchdog ratio.

When the counter wraps from all ones to zero, a pending flag is set. The flag stays set until it is acknowledged. The flag reaches the interrupt output only while the interrupt-disable bit is clear. Software gets a fixed interrupt rate by loading the negative of a period P on each interrupt return. An overflow then follows every P counts. For example, P = 217 at a 50 MHz cycle rate gives about 4.34 us. A load also empties the prescaler, so the first period after a load has its full length.

The block only produces the watchdog tick. Resetting the core is left to logic outside the block. All ports are plain control and status pins. No data stream passes through the block, so no valid/ready handshake and no back-pressure apply.

Top module: `rtc_counter`

## Requirements
- R1: After reset: `cnt_value` is 0, `irq_pend` is 0, `irq_out` is 0, and `cfg_q` equals parameter `OPT_RST` (default 8'hFF), so `cnt_map` is 1.
- R2: A pulse on `opt_wr` stores `opt_wdata` into `cfg_q` on the next clock. Bit 7 of `cfg_q` drives `cnt_map`. The field layout is: bit 7 map-enable, bit 6 interrupt-disable, bit 5 pin source, bit 4 falling edge, bit 3 prescaler-to-watchdog, bits 2:0 prescale code n.
- R3: When bit 5 is 0 and the counter runs at 1:1 (bit 3 is 1), each clock with `cycle_en` high adds one to `cnt_value`, and the new value shows after that edge. The count wraps modulo 256.
- R4: When bit 5 is 1, the counter advances on edges of `ext_pin`. Bit 4 = 0 selects rising edges and bit 4 = 1 selects falling edges. The pin passes through two synchroniser flops, so the count shows on the third clock edge after the pin change. The opposite edge and `cycle_en` are ignored in this mode.
- R5: When bit 3 is 0, the prescaler serves the counter. The counter then advances once per 2^(n+1) source events, which spans 1:2 to 1:256.
- R6: When bit 3 is 1, `wdt_tick` pulses once per 2^n `wdt_base` pulses, which spans 1:1 to 1:128, and the counter runs at 1:1. When bit 3 is 0, `wdt_tick` follows `wdt_base`. `wdt_tick` is never high unless `wdt_base` is high.
- R7: `ld_strobe` writes `ld_value` into the counter on the next clock and clears the prescaler count. A load wins over an increment in the same cycle.
- R8: An advance from 8'hFF to 8'h00 sets `irq_pend`. The flag holds until `irq_ack` is high. If an overflow and `irq_ack` happen in the same cycle, the flag stays set.
- R9: `irq_out` is high exactly when `irq_pend` is 1 and bit 6 of `cfg_q` is 0.
- R10: Loading 256 - P and then giving P counts raises `irq_pend` on count P and not before. Reloading on acknowledge repeats the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_en | input | 1 | One pulse per instruction cycle |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_base | input | 1 | Watchdog timebase pulse |
| opt_wr | input | 1 | Configuration write strobe |
| opt_wdata | input | 8 | Configuration write data |
| ld_strobe | input | 1 | Counter load strobe |
| ld_value | input | CNT_W | Counter load value |
| irq_ack | input | 1 | Clears the pending flag |
| cnt_value | output | CNT_W | Current count |
| cfg_q | output | 8 | Configuration register |
| cnt_map | output | 1 | Counter-mapped select (bit 7) |
| irq_pend | output | 1 | Overflow pending flag |
| irq_out | output | 1 | Interrupt request |
| wdt_tick | output | 1 | Watchdog tick |

## Verification
The bench builds the block with its defaults: CNT_W = 8 and OPT_RST = 8'hFF. With an 8-bit count, a wrap needs at most 256 events, and the widest counter ratio of 1:256 is reached with the top prescale code in a single short vector. These sizes also allow the full 217-count reload period to be run twice in a directed test. The all-ones reset value makes the reset state differ from every configuration the bench writes later.

// File: rtl/rtc_counter_pkg.sv
package rtc_counter_pkg;
  localparam int PS_CODE_W = 3;
  localparam int PS_W      = 1 << PS_CODE_W;

  // Configuration layout, MSB first; bit positions are software-visible.
  typedef struct packed {
    logic                 map_en;     // bit 7
    logic                 irq_dis;    // bit 6
    logic                 src_pin;    // bit 5
    logic                 fall_edge;  // bit 4
    logic                 ps_to_wdt;  // bit 3
    logic [PS_CODE_W-1:0] ps_code;    // bits 2:0
  } cfg_t;
endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // chain[SYNC_N-1] is the synchronised level, chain[SYNC_N] its previous value
  logic [SYNC_N:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_N-1:0], pin_i};
  end

  logic rise, fall;
  assign rise   =  chain[SYNC_N-1] & ~chain[SYNC_N];
  assign fall   = ~chain[SYNC_N-1] &  chain[SYNC_N];
  assign edge_o = fall_sel_i ? fall : rise;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_counter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 src_evt_i,
  input  logic                 wdt_base_i,
  input  logic                 to_wdt_i,
  input  logic [PS_CODE_W-1:0] code_i,
  output logic                 cnt_tick_o,
  output logic                 wdt_tick_o
);
  logic [PS_W-1:0] pre_q;
  logic [PS_W-1:0] mask_cnt, mask_wdt, mask;
  logic            ps_in, hit;

  // Counter ratio 2^(n+1): n+1 low ones; watchdog ratio 2^n: n low ones.
  always_comb begin
    for (int i = 0; i < PS_W; i++) begin
      mask_cnt[i] = (i <= int'(code_i));
      mask_wdt[i] = (i <  int'(code_i));
    end
  end

  assign mask  = to_wdt_i ? mask_wdt : mask_cnt;
  assign ps_in = to_wdt_i ? wdt_base_i : src_evt_i;
  assign hit   = ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (ps_in) pre_q <= pre_q + 1'b1;
  end

  assign cnt_tick_o = to_wdt_i ? src_evt_i : (src_evt_i & hit);
  assign wdt_tick_o = to_wdt_i ? (wdt_base_i & hit) : wdt_base_i;
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, wrap;

  assign wrap = tick_i & ~ld_i & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // Overflow has priority over acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (wrap)  pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_counter_pkg::*;
#(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] OPT_RST = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_en,
  input  logic             ext_pin,
  input  logic             wdt_base,
  input  logic             opt_wr,
  input  logic [7:0]       opt_wdata,
  input  logic             ld_strobe,
  input  logic [CNT_W-1:0] ld_value,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cnt_value,
  output logic [7:0]       cfg_q,
  output logic             cnt_map,
  output logic             irq_pend,
  output logic             irq_out,
  output logic             wdt_tick
);
  cfg_t cfg;
  logic pin_edge, src_evt, cnt_tick, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= cfg_t'(OPT_RST);
    else if (opt_wr) cfg <= cfg_t'(opt_wdata);
  end

  rtc_edge_sync #(.SYNC_N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin),
    .fall_sel_i(cfg.fall_edge), .edge_o(pin_edge)
  );

  assign src_evt = cfg.src_pin ? pin_edge : cycle_en;

  rtc_prescaler u_ps (
    .clk(clk), .rst_n(rst_n), .clr_i(ld_strobe),
    .src_evt_i(src_evt), .wdt_base_i(wdt_base),
    .to_wdt_i(cfg.ps_to_wdt), .code_i(cfg.ps_code),
    .cnt_tick_o(cnt_tick), .wdt_tick_o(wdt_tick)
  );

  rtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(cnt_tick),
    .ld_i(ld_strobe), .ld_val_i(ld_value), .ack_i(irq_ack),
    .cnt_o(cnt_value), .pend_o(pend)
  );

  assign cfg_q    = cfg;
  assign cnt_map  = cfg.map_en;
  assign irq_pend = pend;
  assign irq_out  = pend & ~cfg.irq_dis;
endmodule

module rtc_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_base,
  input logic             ld_strobe,
  input logic [CNT_W-1:0] ld_value,
  input logic             irq_ack,
  input logic [CNT_W-1:0] cnt_value,
  input logic [7:0]       cfg_q,
  input logic             irq_pend,
  input logic             irq_out,
  input logic             wdt_tick
);
  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |=> cnt_value == $past(ld_value));
  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_strobe |=> (cnt_value == $past(cnt_value)) ||
                   (cnt_value == CNT_W'($past(cnt_value) + 1'b1)));
  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_value == '1 && !ld_strobe) |=> (cnt_value == '1) || irq_pend);
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_ack) |=> irq_pend);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[6] |-> !irq_out);
  // R6
  wdt_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick |-> wdt_base);
endmodule

bind rtc_counter rtc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_base(wdt_base), .ld_strobe(ld_strobe),
  .ld_value(ld_value), .irq_ack(irq_ack), .cnt_value(cnt_value),
  .cfg_q(cfg_q), .irq_pend(irq_pend), .irq_out(irq_out), .wdt_tick(wdt_tick)
);

// File: tb/rtc_counter_bench.sv
module rtc_counter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_en = 0, ext_pin = 0, wdt_base = 0, opt_wr = 0, ld_strobe = 0, irq_ack = 0;
  logic [7:0] opt_wdata = 0, ld_value = 0;
  logic [7:0] cnt_value, cfg_q;
  logic cnt_map, irq_pend, irq_out, wdt_tick;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rtc_counter u_rtc_counter (
    .clk(clk), .rst_n(rst_n), .cycle_en(cycle_en), .ext_pin(ext_pin),
    .wdt_base(wdt_base), .opt_wr(opt_wr), .opt_wdata(opt_wdata),
    .ld_strobe(ld_strobe), .ld_value(ld_value), .irq_ack(irq_ack),
    .cnt_value(cnt_value), .cfg_q(cfg_q), .cnt_map(cnt_map),
    .irq_pend(irq_pend), .irq_out(irq_out), .wdt_tick(wdt_tick)
  );

  // {opt, load, pulses[15:0], expected count}
  localparam logic [39:0] VEC [0:7] = '{
    40'h08_00_0005_05, 40'h08_F0_0014_04, 40'h00_00_0009_04, 40'h02_10_0014_12,
    40'h07_33_00FF_33, 40'h07_33_0100_34, 40'h0B_00_0007_07, 40'h05_00_0040_01
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_opt(input logic [7:0] v);
    @(negedge clk); opt_wr = 1; opt_wdata = v;
    @(negedge clk); opt_wr = 0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); ld_strobe = 1; ld_value = v;
    @(negedge clk); ld_strobe = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); cycle_en = 1; end
    @(negedge clk); cycle_en = 0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  function automatic int wdt_count_dummy(input int x);
    return x;
  endfunction

  int ticks;
  task automatic wdt_pulses(input int n);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_base = 1;
      #1 if (wdt_tick) ticks++;
    end
    @(negedge clk); wdt_base = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_neg(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cnt_value == 0, "R1 count", cnt_value, 0);
    check(irq_pend == 0, "R1 pend", irq_pend, 0);
    check(irq_out == 0, "R1 irq", irq_out, 0);
    check(cfg_q == 8'hFF, "R1 cfg", cfg_q, 8'hFF);
    check(cnt_map == 1, "R1 map", cnt_map, 1);

    // R2 configuration write and map bit
    wr_opt(8'h80);
    check(cfg_q == 8'h80 && cnt_map, "R2 cfg 80", cfg_q, 8'h80);
    wr_opt(8'h08);
    check(cfg_q == 8'h08 && !cnt_map, "R2 cfg 08", cfg_q, 8'h08);

    // R3 / R5 / R6 vector table
    foreach (VEC[k]) begin
      wr_opt(VEC[k][39:32]);
      load(VEC[k][31:24]);
      pulses(int'(VEC[k][23:8]));
      check(cnt_value == VEC[k][7:0], $sformatf("R3/R5/R6 vector %0d", k),
            cnt_value, VEC[k][7:0]);
    end

    // R4 pin source, rising edge, 1:1
    wr_opt(8'h28); load(8'h00);
    pulses(3);
    check(cnt_value == 0, "R4 cycle_en ignored", cnt_value, 0);
    @(negedge clk); ext_pin = 1; wait_neg(2);
    check(cnt_value == 0, "R4 not before sync", cnt_value, 0);
    wait_neg(2);
    check(cnt_value == 1, "R4 rise counted", cnt_value, 1);
    @(negedge clk); ext_pin = 0; wait_neg(4);
    check(cnt_value == 1, "R4 fall ignored", cnt_value, 1);
    wr_opt(8'h38);
    @(negedge clk); ext_pin = 1; wait_neg(4);
    check(cnt_value == 1, "R4 rise ignored", cnt_value, 1);
    @(negedge clk); ext_pin = 0; wait_neg(4);
    check(cnt_value == 2, "R4 fall counted", cnt_value, 2);

    // R6 watchdog ratios
    wr_opt(8'h0B); load(8'h00);
    wdt_pulses(24);
    check(ticks == 3, "R6 wdt 1:8", ticks, 3);
    check(cnt_value == 0, "R6 counter untouched", cnt_value, 0);
    wr_opt(8'h08);
    wdt_pulses(5);
    check(ticks == 5, "R6 wdt 1:1", ticks, 5);
    wr_opt(8'h02);
    wdt_pulses(5);
    check(ticks == 5, "R6 wdt bypass", ticks, 5);

    // R7 load beats increment; load clears prescaler
    wr_opt(8'h08);
    @(negedge clk); cycle_en = 1; ld_strobe = 1; ld_value = 8'h40;
    @(negedge clk); cycle_en = 0; ld_strobe = 0;
    check(cnt_value == 8'h40, "R7 load priority", cnt_value, 8'h40);
    wr_opt(8'h01); load(8'h00);
    pulses(3); load(8'h00); pulses(3);
    check(cnt_value == 0, "R7 prescaler cleared", cnt_value, 0);
    pulses(1);
    check(cnt_value == 1, "R7 after clear", cnt_value, 1);

    // R8 / R9 overflow flag
    wr_opt(8'h08); ack(); load(8'hFF);
    pulses(1);
    check(cnt_value == 0 && irq_pend, "R8 wrap sets pend", irq_pend, 1);
    check(irq_out == 1, "R9 irq enabled", irq_out, 1);
    wait_neg(3);
    check(irq_pend == 1, "R8 pend holds", irq_pend, 1);
    ack();
    check(irq_pend == 0, "R8 ack clears", irq_pend, 0);
    load(8'hFF);
    @(negedge clk); cycle_en = 1; irq_ack = 1;
    @(negedge clk); cycle_en = 0; irq_ack = 0;
    check(irq_pend == 1, "R8 set beats ack", irq_pend, 1);
    wr_opt(8'h48);
    check(irq_pend == 1 && irq_out == 0, "R9 masked", irq_out, 0);

    // R10 periodic reload with P = 217
    wr_opt(8'h08); ack(); load(8'd39);
    pulses(216);
    check(irq_pend == 0, "R10 not early", irq_pend, 0);
    pulses(1);
    check(irq_pend == 1 && cnt_value == 0, "R10 period 1", irq_pend, 1);
    @(negedge clk); irq_ack = 1; ld_strobe = 1; ld_value = 8'd39;
    @(negedge clk); irq_ack = 0; ld_strobe = 0;
    pulses(216);
    check(irq_pend == 0, "R10 reload not early", irq_pend, 0);
    pulses(1);
    check(irq_pend == 1, "R10 period 2", irq_pend, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule